// File: doc/BRIEF.md
# Stretchable External Data Bus Sequencer

This block runs single read and write transfers between a small microcontroller core and an 8-bit external data memory bus. The core raises a one-cycle request with a direction, a 16-bit address and, for writes, a byte of data. The block then plays out an address-valid phase followed by a read or write strobe phase, and finishes with a one-cycle completion pulse. A completed read also returns the captured byte.

A 3-bit stretch setting, held in a small control register inside the block, widens both phases. Slow RAM or memory-mapped peripherals can then be reached without any handshake from the device. Reads and writes follow different width rules. The setting is sampled when a transfer is accepted, so a transfer always runs to completion with the timing it started with.

The bus data path is split into an output byte, an output-enable and an input byte, so the tri-state buffer can sit at the pad ring.

Top module: `ext_bus_ctl`

## Requirements
- R1: The stretch register resets to 1. A `cfg_we` pulse loads `cfg_wdata` into it, and the new value is visible on `cfg_stretch` from the next cycle.
- R2: A request is accepted on a clock edge where `req` is high and `busy` is low. On a read, `bus_aval` is then high for S+1 consecutive cycles, starting in the cycle after acceptance, where S is the stretch value.
- R3: On a read, `bus_rd` is high for S+1 consecutive cycles, starting right after the address-valid phase. `bus_addr` carries the request address throughout the transfer.
- R4: On a write, `bus_aval` is high for S+2 consecutive cycles, starting in the cycle after acceptance.
- R5: On a write, `bus_wr` is high right after the address-valid phase. It stays high for 1 cycle when S is 0 or 1, and for S cycles when S is 2 to 7.
- R6: `done` is high for exactly one cycle, in the cycle after the last strobe cycle. For a read, `rd_data` then holds the `bus_din` value sampled on the last `bus_rd` cycle, and it keeps that value until the next read completes.
- R7: During a write, `bus_doe` is high and `bus_dout` equals the request data on every cycle from the first address-valid cycle to the last write-strobe cycle. `bus_doe` is low at all other times.
- R8: `busy` is high from the cycle after acceptance until the last strobe cycle, and low in the `done` cycle. A request raised while `busy` is high is ignored and starts no transfer.
- R9: The stretch value is latched on acceptance. A register write during a transfer changes only the transfers accepted after it.
- R10: At most one of `bus_aval`, `bus_rd` and `bus_wr` is high in any cycle, and all three are low when idle and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Write strobe for the stretch register |
| cfg_wdata | input | 3 | New stretch value |
| cfg_stretch | output | 3 | Current stretch register contents |
| req | input | 1 | Transfer request, sampled while not busy |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Transfer in progress; requests are ignored |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte captured by the last read |
| bus_addr | output | 16 | External address |
| bus_aval | output | 1 | Address-valid strobe, active high |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_dout | output | 8 | Data driven toward the device |
| bus_doe | output | 1 | Output enable for `bus_dout` |
| bus_din | input | 8 | Data returned by the device |

## Verification
The assertions assume that the core changes `cfg_we` and `req` only between clock edges, and that it never expects a request made while `busy` is high to be queued. The stimulus drives every input on the falling edge and issues requests only after seeing `busy` low. The one exception is a deliberate mid-transfer request, which the bench expects to be dropped. The external device is modelled as a combinational function of `bus_addr`, so `bus_din` is always defined when the read strobe samples it.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_STRB = 2'd2
  } ebc_state_e;
endpackage

// File: rtl/ebc_rst_sync.sv
module ebc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/ebc_cfg_reg.sv
module ebc_cfg_reg #(
  parameter int          SW      = 3,
  parameter logic [SW-1:0] RST_VAL = SW'(1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] wdata,
  output logic [SW-1:0] value
);
  logic [SW-1:0] val_d, val_q;

  always_comb begin
    val_d = val_q;
    if (we) val_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= RST_VAL;
    else        val_q <= val_d;
  end

  assign value = val_q;
endmodule

// File: rtl/ebc_phase_len.sv
module ebc_phase_len #(
  parameter int SW    = 3,
  parameter int CNT_W = SW + 1
) (
  input  logic             wr,
  input  logic [SW-1:0]    stretch,
  output logic [CNT_W-1:0] addr_last,
  output logic [CNT_W-1:0] strb_last
);
  logic [CNT_W-1:0] s_ext;

  assign s_ext = CNT_W'(stretch);

  always_comb begin
    if (wr) begin
      addr_last = s_ext + CNT_W'(1);
      if (s_ext <= CNT_W'(1)) strb_last = '0;
      else                     strb_last = s_ext - CNT_W'(1);
    end else begin
      addr_last = s_ext;
      strb_last = s_ext;
    end
  end
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] stretch_cfg,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] bus_addr,
  output logic          bus_aval,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic [DW-1:0] bus_din
);
  localparam int CNT_W = SW + 1;

  ebc_state_e       state_d, state_q;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             done_d, done_q;
  logic [DW-1:0]    rdata_d, rdata_q;
  logic             wr_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [SW-1:0]    stretch_q;
  logic             accept;
  logic [CNT_W-1:0] addr_last, strb_last;

  ebc_phase_len #(.SW(SW), .CNT_W(CNT_W)) u_len (
    .wr        (wr_q),
    .stretch   (stretch_q),
    .addr_last (addr_last),
    .strb_last (strb_last)
  );

  assign accept = (state_q == ST_IDLE) && req;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    rdata_d = rdata_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          state_d = ST_ADDR;
          cnt_d   = '0;
        end
      end
      ST_ADDR: begin
        if (cnt_q == addr_last) begin
          state_d = ST_STRB;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_STRB: begin
        if (cnt_q == strb_last) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
          done_d  = 1'b1;
          if (!wr_q) rdata_d = bus_din;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      stretch_q <= '0;
    end else if (accept) begin
      wr_q      <= req_wr;
      addr_q    <= req_addr;
      wdata_q   <= req_wdata;
      stretch_q <= stretch_cfg;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign rd_data  = rdata_q;
  assign bus_addr = addr_q;
  assign bus_aval = (state_q == ST_ADDR);
  assign bus_rd   = (state_q == ST_STRB) && !wr_q;
  assign bus_wr   = (state_q == ST_STRB) && wr_q;
  assign bus_doe  = busy && wr_q;
  assign bus_dout = bus_doe ? wdata_q : '0;
endmodule

// File: rtl/ext_bus_ctl.sv
module ext_bus_ctl #(
  parameter int            AW          = 16,
  parameter int            DW          = 8,
  parameter int            SW          = 3,
  parameter logic [SW-1:0] STRETCH_RST = SW'(1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_wdata,
  output logic [SW-1:0] cfg_stretch,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] bus_addr,
  output logic          bus_aval,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic [DW-1:0] bus_din
);
  logic rst_n_sync;

  ebc_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  ebc_cfg_reg #(.SW(SW), .RST_VAL(STRETCH_RST)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .value (cfg_stretch)
  );

  ebc_seq #(.AW(AW), .DW(DW), .SW(SW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .stretch_cfg (cfg_stretch),
    .req         (req),
    .req_wr      (req_wr),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .busy        (busy),
    .done        (done),
    .rd_data     (rd_data),
    .bus_addr    (bus_addr),
    .bus_aval    (bus_aval),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_dout    (bus_dout),
    .bus_doe     (bus_doe),
    .bus_din     (bus_din)
  );
endmodule

// File: rtl/ext_bus_ctl_chk.sv
module ext_bus_ctl_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [SW-1:0] cfg_wdata,
  input logic [SW-1:0] cfg_stretch,
  input logic          req,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] bus_addr,
  input logic          bus_aval,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_doe
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({bus_aval, bus_rd, bus_wr}) <= 1); // R10

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_stretch == $past(cfg_wdata))); // R1

  AST_AVAL_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_aval) |-> $past(req && !busy)); // R2

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && $past(bus_aval || bus_rd || bus_wr)) |-> $stable(bus_addr)); // R3

  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_WR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> bus_doe); // R7

  AST_DOE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_doe); // R7

  AST_BUSY_COVER: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_aval || bus_rd || bus_wr) |-> busy); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
endmodule

bind ext_bus_ctl ext_bus_ctl_chk #(.AW(AW), .DW(DW), .SW(SW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_wdata   (cfg_wdata),
  .cfg_stretch (cfg_stretch),
  .req         (req),
  .busy        (busy),
  .done        (done),
  .bus_addr    (bus_addr),
  .bus_aval    (bus_aval),
  .bus_rd      (bus_rd),
  .bus_wr      (bus_wr),
  .bus_doe     (bus_doe)
);

// File: tb/tb_ext_bus_ctl.sv
`timescale 1ns/1ps
module tb_ext_bus_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_wdata = '0;
  logic [2:0]  cfg_stretch;
  logic        req = 1'b0;
  logic        req_wr = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy, done;
  logic [7:0]  rd_data;
  logic [15:0] bus_addr;
  logic        bus_aval, bus_rd, bus_wr, bus_doe;
  logic [7:0]  bus_dout, bus_din;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_f(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign bus_din = mem_f(bus_addr);

  ext_bus_ctl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_stretch(cfg_stretch), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
    .bus_addr(bus_addr), .bus_aval(bus_aval), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din)
  );

  typedef struct {
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  data;
    int          na;
    int          ns;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // monitor
  int a_cnt = 0, r_cnt = 0, w_cnt = 0, doe_cnt = 0, dout_bad = 0;
  logic [15:0] addr_seen = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_aval) a_cnt++;
      if (bus_rd) begin r_cnt++; addr_seen = bus_addr; end
      if (bus_wr) begin w_cnt++; addr_seen = bus_addr; end
      if (bus_doe) begin
        doe_cnt++;
        if (q.size() == 0 || bus_dout != q[0].data) dout_bad++;
      end
      if (done) begin
        if (q.size() == 0) begin
          chk("R8 unexpected transfer", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.wr) begin
            chk("R4 write aval width", a_cnt, e.na);
            chk("R5 write strobe width", w_cnt, e.ns);
            chk("R5 no read strobe on write", r_cnt, 0);
            chk("R7 write data cycles", doe_cnt, e.na + e.ns);
            chk("R7 write data value errors", dout_bad, 0);
          end else begin
            chk("R2 read aval width", a_cnt, e.na);
            chk("R3 read strobe width", r_cnt, e.ns);
            chk("R3 no write strobe on read", w_cnt, 0);
            chk("R7 no drive on read", doe_cnt, 0);
            chk("R6 read data", int'(rd_data), int'(e.data));
          end
          chk("R3 bus address", int'(addr_seen), int'(e.addr));
        end
        a_cnt = 0; r_cnt = 0; w_cnt = 0; doe_cnt = 0; dout_bad = 0;
      end
    end
  end

  task automatic set_stretch(int s);
    while (busy) @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 3'(s);
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R1 stretch register load", int'(cfg_stretch), s);
  endtask

  // driver: pushes the expected item, then raises a one-cycle request
  task automatic xfer(logic wr, logic [15:0] a, logic [7:0] d, int s);
    exp_t e;
    while (busy) @(negedge clk);
    e.wr   = wr;
    e.addr = a;
    e.data = wr ? d : mem_f(a);
    e.na   = wr ? s + 2 : s + 1;
    e.ns   = wr ? ((s <= 1) ? 1 : s) : s + 1;
    q.push_back(e);
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0 || busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 stretch reset value", int'(cfg_stretch), 1);
    chk("R8 busy after reset", int'(busy), 0);
    chk("R10 strobes after reset", int'({bus_aval, bus_rd, bus_wr}), 0);
    chk("R7 doe after reset", int'(bus_doe), 0);
    chk("R6 done after reset", int'(done), 0);

    // default stretch of 1
    xfer(1'b0, 16'h1234, 8'h00, 1);
    xfer(1'b1, 16'hBEEF, 8'h3C, 1);
    drain();

    // every stretch setting, both directions
    for (int s = 0; s < 8; s++) begin
      set_stretch(s);
      xfer(1'b0, {5'(s), 11'h2A5}, 8'h00, s);
      xfer(1'b1, {5'(s), 11'h15A}, 8'(8'h90 + s), s);
      drain();
    end

    // back-to-back reads at stretch 0
    set_stretch(0);
    xfer(1'b0, 16'h0F0F, 8'h00, 0);
    xfer(1'b0, 16'hF00F, 8'h00, 0);
    xfer(1'b1, 16'h00FF, 8'h77, 0);
    drain();

    // R9: register write during a transfer affects only later transfers
    set_stretch(2);
    xfer(1'b0, 16'h4242, 8'h00, 2);
    cfg_we = 1'b1; cfg_wdata = 3'd7;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R9 busy while register rewritten", int'(busy), 1);
    xfer(1'b1, 16'h4343, 8'hC3, 7);
    drain();

    // R8: request during a transfer is dropped
    set_stretch(3);
    xfer(1'b1, 16'h5555, 8'hAA, 3);
    chk("R8 busy after acceptance", int'(busy), 1);
    @(negedge clk);
    req = 1'b1; req_wr = 1'b0; req_addr = 16'h6666;
    @(negedge clk);
    req = 1'b0;
    drain();
    repeat (6) @(negedge clk);
    chk("R8 no extra address phase", a_cnt, 0);
    chk("R8 no extra strobe", r_cnt + w_cnt, 0);
    chk("R8 busy after drain", int'(busy), 0);
    chk("R6 read data held", int'(rd_data), int'(mem_f(16'h4242)));

    finish_run();
  end
endmodule